// File: doc/BRIEF.md
# Byte-Lane Multiplexed Bus Slave Bridge

This block sits on the FPGA side of a synchronous, master-driven bus. One 8-bit lane carries both a 24-bit address and 32-bit data words. An active-low address strobe frames the address bytes. An active-low data strobe frames the data bytes. A direction input selects write (high) or read (low).

The bridge gathers the address bytes into a word address. It assembles written bytes into words and hands each word to an internal register or memory port as a single-cycle write request. For reads, it fetches each word from that port and drives the word back onto the lane one byte per cycle. Its output enable is raised only while it drives the lane. A burst continues for as long as the data strobe stays low, and the word address advances by one for each further word.

The internal read port is combinational: `reg_rdata` must reflect `reg_addr` in the same cycle that `reg_re` is high. The master inserts one wait cycle, with both strobes high, between the last address byte and the first data byte of a read.

Top module: `mbs_bus_bridge`

## Requirements
- R1: While reset is held and just after it is released, `bus_d_oe`, `reg_we` and `reg_re` are all low.
- R2: Three consecutive cycles with `bus_ale_n` low load the word address, most significant byte first: bits 23:16, then 15:8, then 7:0. Further address cycles beyond the third are ignored.
- R3: During a write (`bus_wr` high, `bus_den_n` low), four data cycles form one word, most significant byte first. In the cycle after the fourth byte, `reg_we` is high for exactly one cycle, with that word on `reg_wdata` and its address on `reg_addr`.
- R4: For a read (`bus_wr` low), `reg_re` is high in the cycle right after the third address byte, with the captured address on `reg_addr`. On the following data cycles, the fetched word is driven on `bus_d_out`, most significant byte first.
- R5: `bus_d_oe` is high exactly in the cycles where `bus_den_n` is low and `bus_wr` is low. It is never high while a write is issued.
- R6: In a write burst, each further word is written to the previous word address plus one.
- R7: In a read burst, in the cycle that drives the fourth byte of each word, `reg_re` is high with the next word address. This prefetches the next word, so consecutive words stream with no gap.
- R8: The word address wraps from 0xFFFFFF to 0x000000 in both write and read bursts.
- R9: Taking `bus_ale_n` low after a cycle in which it was high drops any partial data word and restarts address capture at bits 23:16.
- R10: A cycle with both strobes high clears the data byte count. A partial word followed by such a cycle is dropped, and the next data byte starts a new word at the same address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and internal clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_ale_n | input | 1 | Address strobe, active low |
| bus_den_n | input | 1 | Data strobe, active low |
| bus_wr | input | 1 | Direction: 1 write, 0 read |
| bus_d_in | input | 8 | Byte lane as seen by the bridge |
| bus_d_out | output | 8 | Read byte driven by the bridge |
| bus_d_oe | output | 1 | Lane drive enable for `bus_d_out` |
| reg_addr | output | 24 | Word address of the internal request |
| reg_wdata | output | 32 | Write word |
| reg_we | output | 1 | One-cycle write request |
| reg_re | output | 1 | One-cycle read request |
| reg_rdata | input | 32 | Read word, valid in the same cycle as `reg_re` |

## Verification
A wrong byte counter shows up at once in the next word. Its bytes appear rotated on `bus_d_out`, or `reg_we` fires one or more bytes early or late with a shifted `reg_wdata`. A stale or mis-advanced word address shows at the next request, as a wrong `reg_addr` on the second word of a burst or after the wrap. A missing restart or idle clear is seen in the first request of the following transaction. The bench therefore compares every request and every driven byte of each transaction against a word model that it builds itself.

// File: rtl/mbs_pkg.sv
// Package: shared widths of the byte-lane bridge.
// Assumes the address and data widths are whole multiples of the lane width.
package mbs_pkg;
    localparam int unsigned MBS_LANE_W = 8;
    localparam int unsigned MBS_ADDR_W = 24;
    localparam int unsigned MBS_DATA_W = 32;
endpackage

// File: rtl/mbs_addr_capture.sv
// Module: collects address bytes into the word address and advances it
// during bursts. A new address strobe after a high cycle restarts capture.
// Assumes word_inc never coincides with an address cycle.
module mbs_addr_capture
    import mbs_pkg::*;
#(
    parameter int unsigned ADDR_W = MBS_ADDR_W,
    parameter int unsigned LANE_W = MBS_LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_n,
    input  logic              den_n,
    input  logic [LANE_W-1:0] lane_in,
    input  logic              word_inc,
    output logic [ADDR_W-1:0] word_addr,
    output logic              addr_done
);
    localparam int unsigned NB = ADDR_W / LANE_W;
    localparam int unsigned CW = $clog2(NB + 1);

    logic [CW-1:0] acnt;
    logic [CW-1:0] idx;
    logic          ale_q;

    // Byte slot for this cycle: a fresh strobe restarts at the top byte.
    always_comb idx = (!ale_n && ale_q) ? '0 : acnt;

    // Shift in address bytes, clear the count on idle, step during bursts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acnt      <= '0;
            ale_q     <= 1'b1;
            word_addr <= '0;
            addr_done <= 1'b0;
        end else begin
            ale_q     <= ale_n;
            addr_done <= 1'b0;
            if (!ale_n) begin
                if (idx < CW'(NB)) begin
                    word_addr <= {word_addr[ADDR_W-LANE_W-1:0], lane_in};
                    acnt      <= idx + 1'b1;
                    addr_done <= (idx == CW'(NB - 1));
                end
            end else begin
                if (den_n) begin
                    acnt <= '0;
                end
                if (word_inc) begin
                    word_addr <= word_addr + 1'b1;
                end
            end
        end
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_n && word_inc) |=> (word_addr == $past(word_addr) + 1'b1)); // R6 R8

    AST_ADDR_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_done |=> !addr_done); // R2
endmodule

// File: rtl/mbs_wr_assembler.sv
// Module: packs written bytes into words, top byte first, and issues one
// write request per word in the cycle after its last byte.
// Assumes the word address is stable until word_inc takes effect.
module mbs_wr_assembler
    import mbs_pkg::*;
#(
    parameter int unsigned ADDR_W = MBS_ADDR_W,
    parameter int unsigned DATA_W = MBS_DATA_W,
    parameter int unsigned LANE_W = MBS_LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_n,
    input  logic              den_n,
    input  logic              wr,
    input  logic [LANE_W-1:0] lane_in,
    input  logic [ADDR_W-1:0] word_addr,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              word_inc
);
    localparam int unsigned NB = DATA_W / LANE_W;
    localparam int unsigned CW = $clog2(NB);

    logic [CW-1:0]     dcnt;
    logic [DATA_W-1:0] shreg;
    logic              take;
    logic              last;

    // Decode a write data cycle and the last byte of a word.
    always_comb begin
        take     = !den_n && wr && ale_n;
        last     = take && (dcnt == CW'(NB - 1));
        word_inc = last;
    end

    // Count and shift bytes; launch the write on the final byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcnt    <= '0;
            shreg   <= '0;
            wr_req  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_req <= 1'b0;
            if (!ale_n || den_n) begin
                dcnt <= '0;
            end else if (take) begin
                shreg <= {shreg[DATA_W-LANE_W-1:0], lane_in};
                if (last) begin
                    dcnt    <= '0;
                    wr_req  <= 1'b1;
                    wr_data <= {shreg[DATA_W-LANE_W-1:0], lane_in};
                    wr_addr <= word_addr;
                end else begin
                    dcnt <= dcnt + 1'b1;
                end
            end
        end
    end

    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req); // R3

    AST_WR_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> $past(!den_n && wr)); // R3

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_n && den_n) |=> (dcnt == '0)); // R10
endmodule

// File: rtl/mbs_rd_server.sv
// Module: fetches read words and drives them, top byte first, onto the lane.
// It prefetches the next word on the last byte of each word.
// Assumes a combinational read port: rd_data_in follows rd_addr in-cycle.
module mbs_rd_server
    import mbs_pkg::*;
#(
    parameter int unsigned ADDR_W = MBS_ADDR_W,
    parameter int unsigned DATA_W = MBS_DATA_W,
    parameter int unsigned LANE_W = MBS_LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_n,
    input  logic              den_n,
    input  logic              wr,
    input  logic              fetch_first,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [DATA_W-1:0] rd_data_in,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [LANE_W-1:0] lane_out,
    output logic              lane_oe,
    output logic              word_inc
);
    localparam int unsigned NB = DATA_W / LANE_W;
    localparam int unsigned CW = $clog2(NB);

    logic [CW-1:0]     dcnt;
    logic [DATA_W-1:0] hold;
    logic              give;
    logic              last;

    // Decode read data cycles, the request and its address.
    always_comb begin
        give     = !den_n && !wr && ale_n;
        last     = give && (dcnt == CW'(NB - 1));
        word_inc = last;
        rd_req   = fetch_first || last;
        rd_addr  = fetch_first ? word_addr : word_addr + 1'b1;
        lane_oe  = !den_n && !wr;
    end

    // Select the byte for this data cycle, top byte first.
    always_comb lane_out = hold[(NB - 1 - int'(dcnt)) * LANE_W +: LANE_W];

    // Load fetched words and step the byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcnt <= '0;
            hold <= '0;
        end else begin
            if (rd_req) begin
                hold <= rd_data_in;
            end
            if (!ale_n || den_n) begin
                dcnt <= '0;
            end else if (give) begin
                dcnt <= last ? '0 : dcnt + 1'b1;
            end
        end
    end

    AST_FETCH_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_first |-> $past(!ale_n)); // R4
endmodule

// File: rtl/mbs_bus_bridge.sv
// Module: top of the byte-lane bridge. It joins address capture, write
// assembly and read serving onto one internal request port.
// Assumes the master keeps the direction stable through a transaction and
// leaves one idle cycle between the address and the data of a read.
module mbs_bus_bridge
    import mbs_pkg::*;
#(
    parameter int unsigned ADDR_W = MBS_ADDR_W,
    parameter int unsigned DATA_W = MBS_DATA_W,
    parameter int unsigned LANE_W = MBS_LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ale_n,
    input  logic              bus_den_n,
    input  logic              bus_wr,
    input  logic [LANE_W-1:0] bus_d_in,
    output logic [LANE_W-1:0] bus_d_out,
    output logic              bus_d_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic [ADDR_W-1:0] word_addr;
    logic              addr_done;
    logic              inc_w;
    logic              inc_r;
    logic              word_inc;
    logic              fetch_first;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_req;

    // Combine the step requests and detect the first fetch of a read.
    always_comb begin
        word_inc    = inc_w || inc_r;
        fetch_first = addr_done && !bus_wr;
    end

    mbs_addr_capture #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ale_n     (bus_ale_n),
        .den_n     (bus_den_n),
        .lane_in   (bus_d_in),
        .word_inc  (word_inc),
        .word_addr (word_addr),
        .addr_done (addr_done)
    );

    mbs_wr_assembler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ale_n     (bus_ale_n),
        .den_n     (bus_den_n),
        .wr        (bus_wr),
        .lane_in   (bus_d_in),
        .word_addr (word_addr),
        .wr_req    (reg_we),
        .wr_addr   (wr_addr),
        .wr_data   (reg_wdata),
        .word_inc  (inc_w)
    );

    mbs_rd_server #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .ale_n       (bus_ale_n),
        .den_n       (bus_den_n),
        .wr          (bus_wr),
        .fetch_first (fetch_first),
        .word_addr   (word_addr),
        .rd_data_in  (reg_rdata),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .lane_out    (bus_d_out),
        .lane_oe     (bus_d_oe),
        .word_inc    (inc_r)
    );

    // Route the request address from whichever side is active.
    always_comb begin
        reg_re   = rd_req;
        reg_addr = reg_we ? wr_addr : rd_addr;
    end

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re)); // R4

    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !bus_d_oe); // R5
endmodule

// File: tb/mbs_bus_bridge_test.sv
module mbs_bus_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale_n = 1'b1;
    logic        den_n = 1'b1;
    logic        wr_s = 1'b0;
    logic [7:0]  din = 8'h00;
    logic [7:0]  dout;
    logic        doe;
    logic [23:0] raddr;
    logic [31:0] wdata;
    logic        we;
    logic        re;
    logic [31:0] rdata;

    int checks = 0;
    int fails  = 0;
    int oe_err = 0;

    logic [55:0] wq[$];
    logic [23:0] rq[$];
    logic [7:0]  bq[$];

    always #2 clk = ~clk;

    function automatic logic [31:0] pat(input logic [23:0] a);
        return {a[7:0] ^ 8'hC3, a};
    endfunction

    assign rdata = pat(raddr);

    mbs_bus_bridge uut (
        .clk(clk), .rst_n(rst_n), .bus_ale_n(ale_n), .bus_den_n(den_n),
        .bus_wr(wr_s), .bus_d_in(din), .bus_d_out(dout), .bus_d_oe(doe),
        .reg_addr(raddr), .reg_wdata(wdata), .reg_we(we), .reg_re(re),
        .reg_rdata(rdata)
    );

    // Log requests and driven bytes mid-cycle; check the drive enable.
    always @(negedge clk) begin
        if (rst_n) begin
            if (we)  wq.push_back({raddr, wdata});
            if (re)  rq.push_back(raddr);
            if (doe) bq.push_back(dout);
            if (doe != (!den_n && !wr_s)) oe_err++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus(input logic a, input logic d, input logic w, input logic [7:0] b);
        @(posedge clk); #1;
        ale_n = a; den_n = d; wr_s = w; din = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bus(1'b1, 1'b1, wr_s, 8'h00);
    endtask

    task automatic send_addr(input logic [23:0] a, input logic w);
        bus(1'b0, 1'b1, w, a[23:16]);
        bus(1'b0, 1'b1, w, a[15:8]);
        bus(1'b0, 1'b1, w, a[7:0]);
    endtask

    task automatic send_word(input logic [31:0] d);
        for (int i = 3; i >= 0; i--) bus(1'b1, 1'b0, 1'b1, d[i*8 +: 8]);
    endtask

    task automatic clear_logs();
        wq.delete(); rq.delete(); bq.delete();
    endtask

    // Burst write of n words starting at a; checks every request.
    task automatic do_write(input logic [23:0] a, input int n, input logic [31:0] seed,
                            input string req);
        clear_logs();
        send_addr(a, 1'b1);
        for (int i = 0; i < n; i++) send_word(seed + i * 32'h1122_3344);
        idle(3);
        chk(wq.size() == n, req, "write count", wq.size(), n);
        chk(bq.size() == 0, "R5", "bytes driven on write", bq.size(), 0);
        for (int i = 0; i < n && i < wq.size(); i++)
            chk(wq[i] == {a + 24'(i), seed + i * 32'h1122_3344}, req, "write addr/data",
                wq[i], {a + 24'(i), seed + i * 32'h1122_3344});
    endtask

    // Burst read of n words starting at a; checks fetches and bytes.
    task automatic do_read(input logic [23:0] a, input int n, input string req);
        clear_logs();
        send_addr(a, 1'b0);
        idle(1);
        for (int i = 0; i < 4 * n; i++) bus(1'b1, 1'b0, 1'b0, 8'h00);
        idle(3);
        chk(rq.size() == n + 1, req, "fetch count", rq.size(), n + 1);
        for (int i = 0; i <= n && i < rq.size(); i++)
            chk(rq[i] == a + 24'(i), req, "fetch addr", rq[i], a + 24'(i));
        chk(bq.size() == 4 * n, "R5", "driven byte count", bq.size(), 4 * n);
        for (int i = 0; i < 4 * n && i < bq.size(); i++) begin
            logic [31:0] w;
            w = pat(a + 24'(i / 4));
            chk(bq[i] == w[(3 - i % 4) * 8 +: 8], req, "read byte", bq[i], w[(3 - i % 4) * 8 +: 8]);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!doe && !we && !re, "R1", "outputs in reset", {doe, we, re}, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        chk(!doe && !we && !re, "R1", "outputs after reset", {doe, we, re}, 0);
    endtask

    task automatic t_restart();
        clear_logs();
        bus(1'b0, 1'b1, 1'b1, 8'hAA);
        bus(1'b0, 1'b1, 1'b1, 8'hBB);
        idle(1);
        send_addr(24'h123456, 1'b1);
        bus(1'b1, 1'b0, 1'b1, 8'h77);
        bus(1'b1, 1'b0, 1'b1, 8'h88);
        send_addr(24'h0A0B0C, 1'b1);
        send_word(32'hCAFE_F00D);
        idle(3);
        chk(wq.size() == 1, "R9", "write count after restart", wq.size(), 1);
        if (wq.size() > 0)
            chk(wq[0] == {24'h0A0B0C, 32'hCAFE_F00D}, "R9", "restarted write",
                wq[0], {24'h0A0B0C, 32'hCAFE_F00D});
    endtask

    task automatic t_idle_clear();
        clear_logs();
        send_addr(24'h00BEEF, 1'b1);
        bus(1'b1, 1'b0, 1'b1, 8'h11);
        bus(1'b1, 1'b0, 1'b1, 8'h22);
        idle(1);
        send_word(32'h8765_4321);
        idle(3);
        chk(wq.size() == 1, "R10", "write count after idle", wq.size(), 1);
        if (wq.size() > 0)
            chk(wq[0] == {24'h00BEEF, 32'h8765_4321}, "R10", "word after idle",
                wq[0], {24'h00BEEF, 32'h8765_4321});
    endtask

    task automatic t_extra_addr();
        clear_logs();
        send_addr(24'h345678, 1'b1);
        bus(1'b0, 1'b1, 1'b1, 8'hEE);
        send_word(32'h0BAD_CAFE);
        idle(3);
        chk(wq.size() == 1 && wq[0] == {24'h345678, 32'h0BAD_CAFE}, "R2",
            "fourth address byte ignored", wq.size() > 0 ? wq[0] : 56'h0,
            {24'h345678, 32'h0BAD_CAFE});
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        do_write(24'h123456, 1, 32'hDEAD_BEEF, "R3");
        do_write(24'h00A000, 3, 32'h0102_0304, "R6");
        do_read(24'h654321, 1, "R4");
        do_read(24'h000100, 3, "R7");
        do_write(24'hFFFFFF, 2, 32'h5555_AAAA, "R8");
        do_read(24'hFFFFFF, 2, "R8");
        t_extra_addr();
        t_restart();
        t_idle_clear();
        chk(oe_err == 0, "R5", "drive enable mismatches", oe_err, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule